// File: doc/BRIEF.md
# Disk Port Startup Handshake Controller

This block is the controller side of a two-register port on a 16-bit word bus that a host uses to bring up a disk controller. The initialize/poll register (IP) sits at byte offset 0. The status/address register (SA) sits at byte offset 2. The customary base for the pair is octal 172150, and that decode belongs to the surrounding bus logic. Offsets 0 to 7 of the block arrive on `bus_addr`.

A write of any value to IP restarts the port. SA then shows a one-hot step mask. The host waits for the step bit, writes one configuration word into SA, and the mask moves one position left. This repeats for four steps. The first word gives the interrupt enable, the interrupt vector and the sizes of the two rings. The second and third words give the ring base address and a purge/poll request. A fourth word with bit 0 set puts the port into its run state. In the run state, each host read of IP sends a single-cycle poll strobe to the external ring logic so that it scans its descriptors. Ring descriptors mark controller ownership with bit 15, and that scan is done outside this block.

Errors show in SA as bit 15 together with a small code. Three things raise an error: a bad first word, a write to SA when no step is pending, and the external fatal input. Only a new IP write clears an error. The latched fields are driven out as ports. They change only when a step word is accepted, and a write to IP clears them.

Top module: `ring_port_init`

## Requirements
- R1: After synchronous reset the port is idle: SA reads 0, and `running`, `poll_pulse`, `ring_base`, `host_ie`, `host_vec`, `cmd_ring_lg`, `rsp_ring_lg` and `purge_poll` are all 0.
- R2: IP decodes at byte offset 0 and SA at byte offset 2. An access at any other offset changes nothing and reads 0. A read of IP returns 0.
- R3: A write to IP with any data, unless `fatal_in` is high in the same cycle, clears the error and every latched field. From the next cycle SA reads the step-1 mask 16'o004000.
- R4: Each accepted step word moves the SA mask one bit left, through 16'o004000, 16'o010000, 16'o020000 and 16'o040000. SA never reads back the written word, and while no error is set SA bits 10:0 read 0.
- R5: The step-1 word must have bit 15 set. If it does not, the port enters the error state with code 1 (SA = 16'h8001). When the word is accepted, bit 7 latches to `host_ie`, bits 6:0 to `host_vec`, bits 10:8 to `cmd_ring_lg` and bits 13:11 to `rsp_ring_lg`. The word 16'o100000 therefore sets all of these fields to 0.
- R6: The step-2 word latches to `ring_base[15:0]`. In the step-3 word, bits 5:0 latch to `ring_base[21:16]` and bit 15 latches to `purge_poll`.
- R7: A step-4 word with bit 0 set enters the run state: `running` is 1 and SA reads 0. A step-4 word with bit 0 clear leaves SA at 16'o040000.
- R8: A read of IP in the run state drives `poll_pulse` high for exactly the following cycle. An IP read in any other state, or in the same cycle as `fatal_in`, produces no pulse.
- R9: A write to SA in the idle or run state enters the error state with code 2 (SA = 16'h8002). A write to SA in the error state leaves the code unchanged.
- R10: `fatal_in` enters the error state with code 3 (SA = 16'h8003) from any state. It leaves the run state and takes priority over an IP write or step write in the same cycle, so that write latches nothing.
- R11: The latched fields stay unchanged in the run and error states until the next accepted IP write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Host access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset within the register pair |
| bus_wdata | input | 16 | Host write data |
| bus_rdata | output | 16 | Read data for the addressed register (combinational) |
| fatal_in | input | 1 | Controller fatal condition, sets error code 3 |
| running | output | 1 | Port is in the run state |
| poll_pulse | output | 1 | One-cycle descriptor scan request |
| host_ie | output | 1 | Latched interrupt enable |
| host_vec | output | 7 | Latched interrupt vector field |
| cmd_ring_lg | output | 3 | Latched log2 of command ring size |
| rsp_ring_lg | output | 3 | Latched log2 of response ring size |
| ring_base | output | BASE_W | Latched ring base address |
| purge_poll | output | 1 | Latched purge/poll request flag |

## Verification
Two functions can fall in the same cycle: the fatal input, and a host access that would otherwise advance the handshake, restart it or request a poll. The bench provokes this by driving `fatal_in` together with an IP write, a step-2 write and an IP read in the run state, and it also drives such coincidences in a randomized phase. In each case it judges the next cycle: SA must show code 3, no field may latch and no poll strobe may appear. A reference model checks this on every clock, and assertions check the same outcome.

// File: rtl/rpi_pkg.sv
package rpi_pkg;

    localparam int IP_OFS = 0;
    localparam int SA_OFS = 2;
    localparam logic [15:0] STEP1_MASK = 16'o004000;

    typedef enum logic [2:0] {
        PS_IDLE  = 3'd0,
        PS_S1    = 3'd1,
        PS_S2    = 3'd2,
        PS_S3    = 3'd3,
        PS_S4    = 3'd4,
        PS_RUN   = 3'd5,
        PS_FAULT = 3'd6
    } port_state_e;

    typedef enum logic [1:0] {
        EC_NONE    = 2'd0,
        EC_NO_INIT = 2'd1,
        EC_STRAY   = 2'd2,
        EC_FATAL   = 2'd3
    } err_code_e;

    typedef struct packed {
        logic ip_wr;
        logic ip_rd;
        logic sa_wr;
        logic sa_hit;
    } host_acc_t;

    typedef struct packed {
        logic       ie;
        logic [6:0] vec;
        logic [2:0] cmd_lg;
        logic [2:0] rsp_lg;
    } ring_cfg_t;

    function automatic logic [1:0] step_pos(port_state_e st);
        case (st)
            PS_S2:   return 2'd1;
            PS_S3:   return 2'd2;
            PS_S4:   return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic [15:0] sa_image(port_state_e st, err_code_e ec);
        logic [15:0] v;
        case (st)
            PS_S1, PS_S2, PS_S3, PS_S4: v = STEP1_MASK << step_pos(st);
            PS_FAULT:                   v = {1'b1, 13'd0, ec};
            default:                    v = 16'd0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/rpi_decode.sv
module rpi_decode
    import rpi_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output host_acc_t         acc
);
    localparam logic [ADDR_W-1:0] IP_A = ADDR_W'(IP_OFS);
    localparam logic [ADDR_W-1:0] SA_A = ADDR_W'(SA_OFS);

    logic hit_ip;
    logic hit_sa;

    always_comb begin
        hit_ip     = (bus_addr == IP_A);
        hit_sa     = (bus_addr == SA_A);
        acc.ip_wr  = bus_sel &  bus_wr & hit_ip;
        acc.ip_rd  = bus_sel & ~bus_wr & hit_ip;
        acc.sa_wr  = bus_sel &  bus_wr & hit_sa;
        acc.sa_hit = hit_sa;
    end
endmodule

// File: rtl/rpi_seq.sv
module rpi_seq
    import rpi_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  host_acc_t   acc,
    input  logic        wbit15,
    input  logic        wbit0,
    input  logic        fatal_in,
    output port_state_e state,
    output err_code_e   err,
    output logic        poll_pulse,
    output logic [2:0]  step_take,
    output logic        cfg_clear
);
    port_state_e state_d;
    err_code_e   err_d;
    logic        poll_d;

    always_comb begin
        step_take = '0;
        if (acc.sa_wr && !fatal_in) begin
            case (state)
                PS_S1:   step_take[0] = wbit15;
                PS_S2:   step_take[1] = 1'b1;
                PS_S3:   step_take[2] = 1'b1;
                default: step_take = '0;
            endcase
        end
        cfg_clear = acc.ip_wr && !fatal_in;
        poll_d    = acc.ip_rd && (state == PS_RUN) && !fatal_in;
    end

    always_comb begin
        state_d = state;
        err_d   = err;
        if (fatal_in) begin
            state_d = PS_FAULT;
            err_d   = EC_FATAL;
        end else if (acc.ip_wr) begin
            state_d = PS_S1;
            err_d   = EC_NONE;
        end else if (acc.sa_wr) begin
            case (state)
                PS_S1: begin
                    if (wbit15) begin
                        state_d = PS_S2;
                    end else begin
                        state_d = PS_FAULT;
                        err_d   = EC_NO_INIT;
                    end
                end
                PS_S2: state_d = PS_S3;
                PS_S3: state_d = PS_S4;
                PS_S4: if (wbit0) state_d = PS_RUN;
                PS_IDLE, PS_RUN: begin
                    state_d = PS_FAULT;
                    err_d   = EC_STRAY;
                end
                default: state_d = state;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= PS_IDLE;
            err        <= EC_NONE;
            poll_pulse <= 1'b0;
        end else begin
            state      <= state_d;
            err        <= err_d;
            poll_pulse <= poll_d;
        end
    end
endmodule

// File: rtl/rpi_cfg.sv
module rpi_cfg
    import rpi_pkg::*;
#(
    parameter int BASE_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [2:0]        take,
    input  logic [15:0]       wdata,
    output ring_cfg_t         cfg,
    output logic [BASE_W-1:0] ring_base,
    output logic              purge_poll
);
    localparam int HI_W = BASE_W - 16;

    logic [15:0] base_lo;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cfg        <= '0;
            base_lo    <= '0;
            purge_poll <= 1'b0;
        end else begin
            if (take[0]) begin
                cfg.ie     <= wdata[7];
                cfg.vec    <= wdata[6:0];
                cfg.cmd_lg <= wdata[10:8];
                cfg.rsp_lg <= wdata[13:11];
            end
            if (take[1]) base_lo    <= wdata;
            if (take[2]) purge_poll <= wdata[15];
        end
    end

    generate
        if (HI_W > 0) begin : g_hi
            logic [HI_W-1:0] base_hi;
            always_ff @(posedge clk) begin
                if (rst || clear)  base_hi <= '0;
                else if (take[2])  base_hi <= wdata[HI_W-1:0];
            end
            assign ring_base = {base_hi, base_lo};
        end else begin : g_lo
            assign ring_base = base_lo[BASE_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/ring_port_init.sv
module ring_port_init
    import rpi_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int BASE_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    input  logic              fatal_in,
    output logic              running,
    output logic              poll_pulse,
    output logic              host_ie,
    output logic [6:0]        host_vec,
    output logic [2:0]        cmd_ring_lg,
    output logic [2:0]        rsp_ring_lg,
    output logic [BASE_W-1:0] ring_base,
    output logic              purge_poll
);
    host_acc_t   acc;
    port_state_e state;
    err_code_e   err;
    logic [2:0]  step_take;
    logic        cfg_clear;
    ring_cfg_t   cfg;
    logic [15:0] sa_word;

    rpi_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .acc      (acc)
    );

    rpi_seq u_seq (
        .clk        (clk),
        .rst        (rst),
        .acc        (acc),
        .wbit15     (bus_wdata[15]),
        .wbit0      (bus_wdata[0]),
        .fatal_in   (fatal_in),
        .state      (state),
        .err        (err),
        .poll_pulse (poll_pulse),
        .step_take  (step_take),
        .cfg_clear  (cfg_clear)
    );

    rpi_cfg #(.BASE_W(BASE_W)) u_cfg (
        .clk        (clk),
        .rst        (rst),
        .clear      (cfg_clear),
        .take       (step_take),
        .wdata      (bus_wdata),
        .cfg        (cfg),
        .ring_base  (ring_base),
        .purge_poll (purge_poll)
    );

    always_comb begin
        sa_word     = sa_image(state, err);
        bus_rdata   = acc.sa_hit ? sa_word : 16'd0;
        running     = (state == PS_RUN);
        host_ie     = cfg.ie;
        host_vec    = cfg.vec;
        cmd_ring_lg = cfg.cmd_lg;
        rsp_ring_lg = cfg.rsp_lg;
    end
endmodule

// File: rtl/rpi_chk.sv
module rpi_chk #(
    parameter int ADDR_W = 3,
    parameter int BASE_W = 22
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              fatal_in,
    input logic              running,
    input logic              poll_pulse,
    input logic [BASE_W-1:0] ring_base,
    input logic [15:0]       sa_word
);
    logic ip_write;
    logic ip_read;
    assign ip_write = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(0));
    assign ip_read  = bus_sel && !bus_wr && (bus_addr == ADDR_W'(0));

    // R8
    poll_src_chk: assert property (@(posedge clk) disable iff (rst)
        poll_pulse |-> $past(ip_read && running && !fatal_in));

    // R3
    restart_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (ip_write && !fatal_in) |=> (sa_word == 16'o004000) && !running);

    // R10
    fatal_code_chk: assert property (@(posedge clk) disable iff (rst)
        fatal_in |=> (sa_word == 16'h8003) && !running);

    // R11
    fields_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((running || sa_word[15]) && !ip_write) |=> $stable(ring_base));

    // R7
    run_sa_zero_chk: assert property (@(posedge clk) disable iff (rst)
        running |-> (sa_word == 16'd0));

    // R4
    step_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        !sa_word[15] |-> ($onehot0(sa_word[14:11]) && (sa_word[10:0] == 11'd0)));
endmodule

bind ring_port_init rpi_chk #(.ADDR_W(ADDR_W), .BASE_W(BASE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .fatal_in   (fatal_in),
    .running    (running),
    .poll_pulse (poll_pulse),
    .ring_base  (ring_base),
    .sa_word    (sa_word)
);

// File: tb/tb_ring_port_init.sv
module tb_ring_port_init;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        fatal_in = 1'b0;
    logic        running;
    logic        poll_pulse;
    logic        host_ie;
    logic [6:0]  host_vec;
    logic [2:0]  cmd_ring_lg;
    logic [2:0]  rsp_ring_lg;
    logic [21:0] ring_base;
    logic        purge_poll;

    int tests = 0;
    int fails = 0;
    int cycles = 0;

    ring_port_init dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .fatal_in(fatal_in), .running(running), .poll_pulse(poll_pulse),
        .host_ie(host_ie), .host_vec(host_vec), .cmd_ring_lg(cmd_ring_lg),
        .rsp_ring_lg(rsp_ring_lg), .ring_base(ring_base), .purge_poll(purge_poll)
    );

    always #10 clk = ~clk;

    // Behavioural reference: 0 idle, 1..4 step, 5 run, 6 error
    int          m_st = 0;
    int          m_err = 0;
    bit          m_poll = 0;
    bit          m_ie = 0;
    int          m_vec = 0, m_cmd = 0, m_rsp = 0;
    int          m_base = 0;
    bit          m_purge = 0;

    always @(posedge clk) begin
        bit ipw, ipr, saw;
        ipw = bus_sel && bus_wr && bus_addr == 3'd0;
        ipr = bus_sel && !bus_wr && bus_addr == 3'd0;
        saw = bus_sel && bus_wr && bus_addr == 3'd2;
        m_poll = 0;
        if (rst) begin
            m_st = 0; m_err = 0; m_ie = 0; m_vec = 0; m_cmd = 0; m_rsp = 0;
            m_base = 0; m_purge = 0;
        end else if (fatal_in) begin
            m_st = 6; m_err = 3;
        end else if (ipw) begin
            m_st = 1; m_err = 0; m_ie = 0; m_vec = 0; m_cmd = 0; m_rsp = 0;
            m_base = 0; m_purge = 0;
        end else if (ipr) begin
            if (m_st == 5) m_poll = 1;
        end else if (saw) begin
            if (m_st == 1) begin
                if (bus_wdata[15]) begin
                    m_ie = bus_wdata[7]; m_vec = bus_wdata & 16'h7F;
                    m_cmd = (bus_wdata >> 8) & 7; m_rsp = (bus_wdata >> 11) & 7;
                    m_st = 2;
                end else begin
                    m_st = 6; m_err = 1;
                end
            end else if (m_st == 2) begin
                m_base = (m_base & 32'h3F0000) | bus_wdata; m_st = 3;
            end else if (m_st == 3) begin
                m_base = (m_base & 32'hFFFF) | ((bus_wdata & 16'h3F) << 16);
                m_purge = bus_wdata[15]; m_st = 4;
            end else if (m_st == 4) begin
                if (bus_wdata[0]) m_st = 5;
            end else if (m_st == 0 || m_st == 5) begin
                m_st = 6; m_err = 2;
            end
        end
    end

    function automatic int model_sa();
        if (m_st == 6) return 32'h8000 | m_err;
        if (m_st >= 1 && m_st <= 4) return 32'h0800 << (m_st - 1);
        return 0;
    endfunction

    function automatic string sa_tag();
        if (m_st == 6) return (m_err == 1) ? "R5" : (m_err == 2) ? "R9" : "R10";
        if (m_st >= 1 && m_st <= 4) return "R4";
        if (m_st == 5) return "R7";
        return "R1";
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at cycle %0d", tag, got, exp, cycles);
        end
    endtask

    task automatic compare_all();
        int exp_rd;
        exp_rd = (bus_addr == 3'd2) ? model_sa() : 0;
        chk(sa_tag(), bus_rdata, exp_rd);
        chk("R7", running, (m_st == 5));
        chk("R8", poll_pulse, m_poll);
        chk("R6", ring_base, m_base);
        chk("R6", purge_poll, m_purge);
        chk("R5", host_ie, m_ie);
        chk("R5", host_vec, m_vec);
        chk("R5", cmd_ring_lg, m_cmd);
        chk("R5", rsp_ring_lg, m_rsp);
    endtask

    task automatic cyc(input bit s, input bit w, input logic [2:0] a,
                       input logic [15:0] d, input bit f);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d; fatal_in = f;
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        cyc(0, 0, 3'd2, 16'd0, 0);
    endtask

    task automatic peek_sa(input string tag, input int exp);
        bus_sel = 0; bus_addr = 3'd2;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 50000) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        idle();
        // R1 reset state
        peek_sa("R1", 0);
        chk("R1", running, 0);
        chk("R1", ring_base, 0);

        // R9 stray SA write while idle
        cyc(1, 1, 3'd2, 16'h1234, 0);
        peek_sa("R9", 16'h8002);

        // R3 restart from error
        cyc(1, 1, 3'd0, 16'hFFFF, 0);
        peek_sa("R3", 16'o004000);

        // R2 other offsets ignored, IP reads 0
        cyc(1, 1, 3'd4, 16'h8000, 0);
        peek_sa("R2", 16'o004000);
        cyc(1, 0, 3'd6, 16'd0, 0);
        chk("R2", bus_rdata, 0);
        cyc(1, 0, 3'd0, 16'd0, 0);
        chk("R2", bus_rdata, 0);

        // R4/R5 minimal step-1 word
        cyc(1, 1, 3'd2, 16'o100000, 0);
        peek_sa("R4", 16'o010000);
        chk("R5", host_ie, 0);

        // Full handshake with rich fields
        cyc(1, 1, 3'd0, 16'd0, 0);
        cyc(1, 1, 3'd2, 16'hABAA, 0);
        chk("R5", host_ie, 1);
        chk("R5", host_vec, 7'h2A);
        chk("R5", cmd_ring_lg, 3);
        chk("R5", rsp_ring_lg, 5);
        cyc(1, 1, 3'd2, 16'h1234, 0);
        peek_sa("R4", 16'o020000);
        cyc(1, 1, 3'd2, 16'h802B, 0);
        chk("R6", ring_base, 22'h2B1234);
        chk("R6", purge_poll, 1);
        peek_sa("R4", 16'o040000);
        cyc(1, 1, 3'd2, 16'h0000, 0);
        peek_sa("R7", 16'o040000);
        chk("R7", running, 0);
        cyc(1, 1, 3'd2, 16'h0001, 0);
        chk("R7", running, 1);
        peek_sa("R7", 0);

        // R8 poll strobes
        cyc(1, 0, 3'd0, 16'd0, 0);
        chk("R8", poll_pulse, 1);
        idle();
        chk("R8", poll_pulse, 0);
        cyc(1, 0, 3'd0, 16'd0, 0);
        cyc(1, 0, 3'd0, 16'd0, 0);
        chk("R8", poll_pulse, 1);
        idle();

        // R9 stray write in run, R11 fields held
        cyc(1, 1, 3'd2, 16'h0000, 0);
        peek_sa("R9", 16'h8002);
        chk("R11", ring_base, 22'h2B1234);
        chk("R11", host_vec, 7'h2A);
        cyc(1, 0, 3'd0, 16'd0, 0);
        idle();
        chk("R8", poll_pulse, 0);

        // R5 bad first word, R9 code kept in error
        cyc(1, 1, 3'd0, 16'd0, 0);
        chk("R11", ring_base, 0);
        cyc(1, 1, 3'd2, 16'h7FFF, 0);
        peek_sa("R5", 16'h8001);
        cyc(1, 1, 3'd2, 16'h8000, 0);
        peek_sa("R9", 16'h8001);

        // R10 fatal beats a restart
        cyc(1, 1, 3'd0, 16'd0, 1);
        peek_sa("R10", 16'h8003);
        // fatal during step-2 write latches nothing
        cyc(1, 1, 3'd0, 16'd0, 0);
        cyc(1, 1, 3'd2, 16'h8000, 0);
        cyc(1, 1, 3'd2, 16'h5555, 1);
        chk("R10", ring_base, 0);
        peek_sa("R10", 16'h8003);
        // fatal with IP read in run
        cyc(1, 1, 3'd0, 16'd0, 0);
        cyc(1, 1, 3'd2, 16'h8000, 0);
        cyc(1, 1, 3'd2, 16'h0100, 0);
        cyc(1, 1, 3'd2, 16'h0002, 0);
        cyc(1, 1, 3'd2, 16'h0001, 0);
        chk("R7", running, 1);
        cyc(1, 0, 3'd0, 16'd0, 1);
        chk("R10", poll_pulse, 0);
        chk("R10", running, 0);
        chk("R11", ring_base, 22'h020100);

        // Randomized phase against the model
        for (int i = 0; i < 1500; i++) begin
            logic [31:0] r;
            logic [2:0]  a;
            r = $urandom;
            a = (r[1:0] == 2'd0) ? 3'd0 : (r[1:0] == 2'd3) ? 3'd4 : 3'd2;
            cyc(r[2], r[3] | r[4], a, r[31:16], r[10:5] == 6'd0);
        end

        idle();
        summary();
    end
endmodule